// File: doc/BRIEF.md
# I2C Target Write Receiver with Clock Hold

This block is the receiving end of an I2C write. It watches the SCL and SDA lines (already brought into the system clock domain), spots the START condition, and checks the first byte of each transaction against a 7-bit own address. If the address matches and the direction bit asks for a write, it acknowledges and hands the address byte to the host side. The following data bytes are shifted in and acknowledged the same way. Each byte is presented on a receive register together with a full flag.

The host side sees four things. An enable input gates all bus activity. An acknowledge-level input selects whether the ninth bit of a frame is driven low (acknowledge) or left high (not acknowledge). A one-cycle read strobe clears the full flag. If the host has not taken a byte by the time SCL falls for the eighth bit of the next frame, the block holds SCL low until the strobe arrives.

Both bus lines are open-drain. The block only ever asserts a pull-low enable for each line, and a released line reads high.

Top module: `i2c_rx_target`

## Requirements
- R1: After reset both pull-low outputs are 0, the full flag is 0 and the receive register is 0.
- R2: While the enable input is 0 the block pulls neither line low, never sets the full flag, and does not acknowledge its own address.
- R3: The address is compared only in the first frame after a START. A later byte equal to the own address, inside a transaction addressed elsewhere, is not acknowledged and sets no flag.
- R4: The address byte is accepted when bits 7..1 equal the own address and bit 0 (R/W) is 0. On acceptance, at the rising SCL edge of the ninth clock, the full flag goes to 1, the receive register takes the whole address byte, and SDA is pulled low if the frame's acknowledge level is 0.
- R5: On an address mismatch, or when R/W is 1, the block pulls neither line and ignores the bus until the next START or STOP.
- R6: Data bits are taken MSB first on rising SCL edges. At the ninth rising edge the byte is loaded into the receive register and the full flag is set. Acknowledge level 0 pulls SDA low during that clock; level 1 leaves SDA released. A read strobe clears the flag.
- R7: If the full flag is still 1 when SCL falls for the eighth bit of a frame, SCL is pulled low and held. The previous byte stays in the register, and the hold is released when the read strobe clears the flag.
- R8: The acknowledge level is captured at the eighth falling SCL edge of each frame. A change made while SCL is held applies from the next frame only.
- R9: The acknowledge pull on SDA ends at the falling SCL edge that closes the ninth clock.
- R10: A STOP returns the block to waiting for a START, and bytes clocked after it are not acknowledged. A repeated START makes the next frame an address frame again.
- R11: When the host reads each byte before the next frame's eighth falling edge, SCL is never held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Transfer enable |
| ack_level | input | 1 | Level for the ninth bit: 0 acknowledge, 1 not acknowledge |
| own_addr | input | 7 | Own 7-bit target address |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| rd_strobe | input | 1 | One-cycle host read of the receive register |
| scl_pull | output | 1 | Pull SCL low (clock hold) |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| rx_data | output | 8 | Receive register |
| rx_full | output | 1 | Receive register holds an unread byte |

## Verification
The checker watches every cycle for several timing relations. The full flag may only rise one cycle after an SCL rising edge. A clock hold may only begin right after an SCL falling edge, and only while a byte is unread. The acknowledge pull may only end while SCL is low. A disabled block must release both lines. Other behaviour needs the bench's transactions to show it. That covers whether an address is accepted or refused, the byte values and their bit order, and which acknowledge level a frame uses when the level changes during a hold. It also covers address comparison being limited to the first frame, and the return to address wait after STOP or repeated START.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    // Transaction phase of the receiver
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for a START
        PH_ADDR = 2'd1,   // first frame after START
        PH_DATA = 2'd2,   // addressed, taking data frames
        PH_SKIP = 2'd3    // not addressed, ignoring until START/STOP
    } phase_e;

endpackage

// File: rtl/i2c_rx_lines.sv
// Bus condition detector: SCL edges plus START and STOP, with the
// block's own SDA drive masked out so an acknowledge is never
// mistaken for a bus condition.
module i2c_rx_lines (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic self_low,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);

    typedef struct packed {
        logic scl;
        logic sda;
        logic self_prev;
    } line_s;

    line_s lq, ld;
    logic  own_quiet;

    always_comb begin
        ld           = lq;
        ld.scl       = scl_in;
        ld.sda       = sda_in;
        ld.self_prev = self_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lq.scl       <= 1'b1;
            lq.sda       <= 1'b1;
            lq.self_prev <= 1'b0;
        end else begin
            lq <= ld;
        end
    end

    assign own_quiet  = !self_low && !lq.self_prev;
    assign scl_rise   = scl_in && !lq.scl;
    assign scl_fall   = !scl_in && lq.scl;
    assign start_seen = own_quiet && scl_in && lq.scl && lq.sda && !sda_in;
    assign stop_seen  = own_quiet && scl_in && lq.scl && !lq.sda && sda_in;

endmodule

// File: rtl/i2c_rx_shift.sv
// Frame shifter: collects WIDTH bits MSB first and counts the
// acknowledge clock as position WIDTH+1.
module i2c_rx_shift #(
    parameter  int unsigned WIDTH = 8,
    localparam int unsigned CW    = $clog2(WIDTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             din,
    output logic [CW-1:0]    count,
    output logic [WIDTH-1:0] word
);

    localparam logic [CW-1:0] FULL_POS = CW'(WIDTH);
    localparam logic [CW-1:0] ACK_POS  = CW'(WIDTH + 1);

    logic [CW-1:0]    cnt_q, cnt_d;
    logic [WIDTH-1:0] sh_q, sh_d;

    always_comb begin
        cnt_d = cnt_q;
        sh_d  = sh_q;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            if (cnt_q < FULL_POS) begin
                sh_d  = {sh_q[WIDTH-2:0], din};
                cnt_d = cnt_q + 1'b1;
            end else if (cnt_q == FULL_POS) begin
                cnt_d = ACK_POS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
        end
    end

    assign count = cnt_q;
    assign word  = sh_q;

endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target #(
    parameter  int unsigned ADDR_W  = 7,
    localparam int unsigned FRAME_W = ADDR_W + 1,
    localparam int unsigned CW      = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               ack_level,
    input  logic [ADDR_W-1:0]  own_addr,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               rd_strobe,
    output logic               scl_pull,
    output logic               sda_pull,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_full
);

    import i2c_rx_pkg::*;

    localparam logic [CW-1:0] BYTE_IN = CW'(FRAME_W);
    localparam logic [CW-1:0] ACK_CLK = CW'(FRAME_W + 1);

    typedef struct packed {
        phase_e             phase;
        logic [FRAME_W-1:0] rx_byte;
        logic               full;
        logic               hold;
        logic               sda_low;
        logic               nack_frame;
    } eng_s;

    eng_s q, d;

    logic               scl_rise, scl_fall, start_seen, stop_seen;
    logic               shift_clr;
    logic [CW-1:0]      bit_cnt;
    logic [FRAME_W-1:0] frame_word;
    logic               addr_hit;
    logic               in_frame;

    i2c_rx_lines u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .self_low   (q.sda_low),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    assign shift_clr = !en || start_seen || stop_seen || (scl_fall && bit_cnt == ACK_CLK);

    i2c_rx_shift #(.WIDTH(FRAME_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (shift_clr),
        .step  (scl_rise),
        .din   (sda_in),
        .count (bit_cnt),
        .word  (frame_word)
    );

    assign addr_hit = (frame_word[FRAME_W-1:1] == own_addr) && !frame_word[0];
    assign in_frame = (q.phase == PH_ADDR) || (q.phase == PH_DATA);

    always_comb begin
        d = q;

        if (rd_strobe) begin
            d.full = 1'b0;
        end

        if (!en) begin
            d.phase   = PH_IDLE;
            d.sda_low = 1'b0;
        end else if (stop_seen) begin
            d.phase   = PH_IDLE;
            d.sda_low = 1'b0;
        end else if (start_seen) begin
            d.phase   = PH_ADDR;
            d.sda_low = 1'b0;
        end else if (in_frame) begin
            // eighth falling edge: capture ack level, maybe hold the clock
            if (scl_fall && bit_cnt == BYTE_IN) begin
                d.nack_frame = ack_level;
                if (q.phase == PH_DATA || addr_hit) begin
                    d.hold = q.full;
                end
            end
            // ninth rising edge: accept or refuse the frame
            if (scl_rise && bit_cnt == BYTE_IN) begin
                if (q.phase == PH_ADDR && !addr_hit) begin
                    d.phase = PH_SKIP;
                end else begin
                    d.phase   = PH_DATA;
                    d.rx_byte = frame_word;
                    d.full    = 1'b1;
                    d.sda_low = !q.nack_frame;
                end
            end
            // falling edge closing the ninth clock: free SDA
            if (scl_fall && bit_cnt == ACK_CLK) begin
                d.sda_low = 1'b0;
            end
        end

        if (!en || stop_seen || start_seen) begin
            d.hold = 1'b0;
        end
        d.hold = d.hold && d.full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase      <= PH_IDLE;
            q.rx_byte    <= '0;
            q.full       <= 1'b0;
            q.hold       <= 1'b0;
            q.sda_low    <= 1'b0;
            q.nack_frame <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign scl_pull = q.hold;
    assign sda_pull = q.sda_low;
    assign rx_data  = q.rx_byte;
    assign rx_full  = q.full;

endmodule

// File: rtl/i2c_rx_target_chk.sv
module i2c_rx_target_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic rd_strobe,
    input logic scl_pull,
    input logic sda_pull,
    input logic rx_full
);

    // R2: disabled block frees both lines
    p_release_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sda_pull && !scl_pull));

    // R4: full flag only rises right after an SCL rising edge
    p_full_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> ($past(scl_in) && !$past(scl_in, 2)));

    // R7: a clock hold needs an unread byte
    p_hold_needs_unread_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull |-> rx_full);

    // R7: a hold only begins right after an SCL falling edge
    p_hold_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> (!$past(scl_in) && $past(scl_in, 2)));

    // R6: a read during a hold empties the register
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rx_full && scl_pull) |=> !rx_full);

    // R9: acknowledge drive ends only while SCL is low
    p_ack_release_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_pull) && $past(en)) |-> !$past(scl_in));

endmodule

bind i2c_rx_target i2c_rx_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .scl_in    (scl_in),
    .rd_strobe (rd_strobe),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .rx_full   (rx_full)
);

// File: tb/tb_i2c_rx_target.sv
module tb_i2c_rx_target;

    localparam int HALF = 10;
    localparam logic [6:0] OWN = 7'h5A;
    localparam int NV = 5;
    // {addr[6:0], rw, data0[7:0], data1[7:0], ack_level, expect_match}
    localparam logic [25:0] VEC [NV] = '{
        {7'h5A, 1'b0, 8'hA5, 8'h3C, 1'b0, 1'b1},
        {7'h5A, 1'b1, 8'h11, 8'h22, 1'b0, 1'b0},
        {7'h2D, 1'b0, 8'h5A, 8'hB4, 1'b0, 1'b0},
        {7'h5A, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b1},
        {7'h5B, 1'b0, 8'h80, 8'h01, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic ack_level = 1'b0;
    logic rd_strobe = 1'b0;
    logic ctl_scl_low = 1'b0;
    logic ctl_sda_low = 1'b0;
    logic scl_pull, sda_pull, rx_full;
    logic [7:0] rx_data;
    logic scl_line, sda_line;
    logic hold_seen = 1'b0;

    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign scl_line = !(ctl_scl_low || scl_pull);
    assign sda_line = !(ctl_sda_low || sda_pull);

    i2c_rx_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ack_level (ack_level),
        .own_addr  (OWN),
        .scl_in    (scl_line),
        .sda_in    (sda_line),
        .rd_strobe (rd_strobe),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .rx_data   (rx_data),
        .rx_full   (rx_full)
    );

    always @(negedge clk) if (scl_pull) hold_seen <= 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        ctl_sda_low = 1'b0; ctl_scl_low = 1'b0; tick(HALF);
        ctl_sda_low = 1'b1; tick(HALF);
        ctl_scl_low = 1'b1; tick(HALF);
    endtask

    task automatic bus_rstart();
        ctl_sda_low = 1'b0; tick(HALF);
        ctl_scl_low = 1'b0; wait_scl_high(); tick(HALF);
        ctl_sda_low = 1'b1; tick(HALF);
        ctl_scl_low = 1'b1; tick(HALF);
    endtask

    task automatic bus_stop();
        ctl_sda_low = 1'b1; tick(HALF);
        ctl_scl_low = 1'b0; wait_scl_high(); tick(HALF);
        ctl_sda_low = 1'b0; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic full_at_ack);
        for (int i = 7; i >= 0; i--) begin
            ctl_sda_low = !b[i]; tick(HALF);
            ctl_scl_low = 1'b0; wait_scl_high(); tick(HALF);
            ctl_scl_low = 1'b1;
        end
        ctl_sda_low = 1'b0; tick(HALF);
        ctl_scl_low = 1'b0; wait_scl_high(); tick(HALF / 2);
        acked = !sda_line;
        full_at_ack = rx_full;
        tick(HALF / 2);
        ctl_scl_low = 1'b1; tick(2);
    endtask

    task automatic rd_pulse();
        rd_strobe = 1'b1; tick(1); rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual run still busy expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ak, fl;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 scl_pull", scl_pull, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 rx_data", rx_data, 0);

        // R2 disabled: own address is ignored
        bus_start();
        send_byte({OWN, 1'b0}, ak, fl);
        chk("R2 no ack while disabled", ak, 0);
        chk("R2 no flag while disabled", fl, 0);
        bus_stop();
        chk("R2 lines free", {sda_pull, scl_pull}, 0);
        en = 1'b1;
        tick(4);

        // table walk: R4 R5 R6 R9 R11
        for (int v = 0; v < NV; v++) begin
            logic [6:0] va;
            logic vrw, vack, vmatch;
            logic [7:0] vd0, vd1;
            {va, vrw, vd0, vd1, vack, vmatch} = VEC[v];
            ack_level = vack;
            hold_seen = 1'b0;
            tick(1);
            bus_start();
            send_byte({va, vrw}, ak, fl);
            if (vmatch) begin
                chk("R4 address ack level", ak, !vack);
                chk("R4 flag at ninth clock", fl, 1);
                chk("R4 address byte held", rx_data, {va, vrw});
                rd_pulse(); tick(1);
                chk("R6 read clears flag", rx_full, 0);
            end else begin
                chk("R5 refused address no ack", ak, 0);
                chk("R5 refused address no flag", fl, 0);
            end
            send_byte(vd0, ak, fl);
            chk("R9 sda freed after ninth clock", sda_pull, 0);
            if (vmatch) begin
                chk("R6 data0 ack level", ak, !vack);
                chk("R6 data0 msb first", rx_data, vd0);
                rd_pulse();
            end else begin
                chk("R5 ignored data0", {ak, rx_full}, 0);
            end
            send_byte(vd1, ak, fl);
            if (vmatch) begin
                chk("R6 data1 ack level", ak, !vack);
                chk("R6 data1 msb first", rx_data, vd1);
                rd_pulse();
            end else begin
                chk("R5 ignored data1", {ak, rx_full}, 0);
            end
            bus_stop();
            chk("R11 no hold when read in time", hold_seen, 0);
        end

        // R3: own address inside a foreign transaction
        ack_level = 1'b0;
        bus_start();
        send_byte({7'h2D, 1'b0}, ak, fl);
        send_byte({OWN, 1'b0}, ak, fl);
        chk("R3 later frame not compared (ack)", ak, 0);
        chk("R3 later frame not compared (flag)", fl, 0);
        bus_stop();

        // R7 / R8: clock hold and deferred ack level
        bus_start();
        send_byte({OWN, 1'b0}, ak, fl);
        rd_pulse();
        send_byte(8'h81, ak, fl);
        chk("R6 first byte acked", ak, 1);
        fork
            send_byte(8'h42, ak, fl);
            begin
                for (int k = 0; k < 1000 && !scl_pull; k++) tick(1);
                tick(HALF * 3);
                chk("R7 hold asserted", scl_pull, 1);
                chk("R7 scl line held low", scl_line, 0);
                chk("R7 pending byte kept", rx_data, 8'h81);
                ack_level = 1'b1;
                rd_pulse();
                chk("R7 hold released by read", scl_pull, 0);
            end
        join
        chk("R8 held frame keeps old ack level", ak, 1);
        chk("R6 second byte loaded", rx_data, 8'h42);
        rd_pulse();
        send_byte(8'h99, ak, fl);
        chk("R8 next frame uses new level", ak, 0);
        chk("R8 nacked byte still loaded", rx_data, 8'h99);
        rd_pulse();

        // R10: repeated START re-compares, STOP returns to wait
        ack_level = 1'b0;
        bus_rstart();
        send_byte({7'h11, 1'b0}, ak, fl);
        chk("R10 restart foreign address", ak, 0);
        send_byte(8'h5A, ak, fl);
        chk("R10 foreign data ignored", {ak, rx_full}, 0);
        bus_rstart();
        send_byte({OWN, 1'b0}, ak, fl);
        chk("R10 restart own address acked", ak, 1);
        rd_pulse();
        send_byte(8'h3E, ak, fl);
        chk("R10 data after restart", rx_data, 8'h3E);
        rd_pulse();
        bus_stop();
        ctl_scl_low = 1'b1; tick(HALF);
        send_byte(8'h77, ak, fl);
        chk("R10 no ack after STOP", {ak, rx_full}, 0);
        bus_stop();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule